// File: doc/BRIEF.md
# GCR Sync and Byte Framer

This block sits between the bit recovery logic and the byte interface of a disk controller that records data in group-coded form. Each data byte is two 4-bit nibbles, and each nibble maps to a 5-bit group, so one byte becomes a 10-bit symbol. All state advances only on a bit strobe. The strobe is a one-cycle qualifier that marks one bit cell of the medium.

In read mode, recovered bits enter a 10-bit shift register. Ten consecutive ones form the sync mark. While the mark is seen, the bit counter stays at zero. After the mark ends, the counter frames the following bits into 10-bit symbols. At each symbol boundary, ready pulses low and the symbol is decoded into a byte. Error pulses low together with ready when either 5-bit group is not a legal code. In write mode, the parallel byte is encoded at each symbol boundary, or replaced by an all-ones sync mark, and loaded into a write register. That register then shifts out one bit per strobe, most significant bit first.

Top module: `gcr_framer`

## Requirements
- R1: Reset is synchronous and active high. While reset is held and after release, before any strobe, sync_n, ready_n and error_n are 1, and rd_byte and wr_bit are 0.
- R2: In read mode, each strobe shifts the read register left and places bit_in in its least significant bit. The register keeps the last ten bits received; the oldest of them sits in bit 9. In write mode, a 0 is shifted in instead of bit_in.
- R3: Sync is evaluated at every strobe. After a strobe in read mode that leaves the last ten received bits all at one, sync_n is 0. After any other strobe, sync_n is 1.
- R4: While sync holds, the bit counter is 0. The strobe that ends sync also leaves the counter at 0. Every other strobe advances the counter, and it wraps from 9 to 0. ready_n is 0 exactly while the counter is 9, so the first ready follows the ninth strobe after the strobe that ended sync.
- R5: ready_n stays low for one strobe interval: it returns to 1 at the next strobe.
- R6: At a strobe that brings ready_n low in read mode, rd_byte captures the decoded symbol. The group in bits 9..5 gives the high nibble and the group in bits 4..0 gives the low nibble. An illegal group decodes as nibble 0. rd_byte keeps its value at all other times.
- R7: error_n is 0 only while ready_n is 0, and only if that boundary strobe came in read mode with at least one illegal group in the symbol.
- R8: The nibble-to-group code, for nibbles 0 to F in hex, is 0A 0B 12 13 0E 0F 16 17 09 19 1A 1B 0D 1D 1E 15. No other 5-bit value is legal.
- R9: In write mode with mode_sel 0, at the strobe that brings ready_n low, the write register loads the symbol {code(wr_byte[7:4]), code(wr_byte[3:0])}. wr_bit shows bit 9 at once. The nine strobes that follow shift out the remaining bits, most significant first.
- R10: In write mode with mode_sel 1, the boundary load is ten ones, which writes a sync mark.
- R11: In read mode, wr_bit is 0, and a boundary strobe in read mode loads zeros into the write register.
- R12: With bit_stb low, sync_n, ready_n, error_n and rd_byte keep their values whatever bit_in, wr_byte and mode_sel do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-cycle bit-cell strobe |
| bit_in | input | 1 | Recovered serial bit (read mode) |
| rd_mode | input | 1 | 1 = read direction, 0 = write direction |
| mode_sel | input | 1 | Write mode: 1 writes a sync mark instead of the encoded byte |
| wr_byte | input | 8 | Byte to encode in write mode |
| sync_n | output | 1 | Sync mark detected, active low |
| ready_n | output | 1 | Symbol boundary, active low |
| error_n | output | 1 | Illegal code at boundary, active low |
| rd_byte | output | 8 | Last decoded byte |
| wr_bit | output | 1 | Serial write bit |

## Verification
sync_n, ready_n, error_n and rd_byte are registered at the strobe edge and are due one clock after the strobe. wr_bit follows the write register in the same clock, and in read mode it follows the mode input directly. The bench drives inputs on the falling edge and advances its behavioural model at the rising edge. It compares every output at the next falling edge, so each check looks at the cycle in which the result first becomes valid. Directed checks read whole symbols at the boundary cycle, and serialised write bits one per strobe from the load cycle onward.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    localparam int NIB_W  = 4;
    localparam int GRP_W  = NIB_W + 1;
    localparam int SYM_W  = 2 * GRP_W;
    localparam int BYTE_W = 2 * NIB_W;

    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [GRP_W-1:0]  grp_t;

    typedef struct packed {
        logic ok;
        nib_t nib;
    } nib_dec_t;

    // Combined lookup address: direction flag on top, payload below.
    typedef struct packed {
        logic rd;
        sym_t payload;
    } lut_addr_t;

    // Combined lookup result: legality flag, write symbol, read data.
    typedef struct packed {
        logic  valid;
        sym_t  code;
        byte_t data;
    } lut_out_t;

    function automatic grp_t nib_to_grp(input nib_t n);
        grp_t g;
        case (n)
            4'h0: g = 5'b01010;
            4'h1: g = 5'b01011;
            4'h2: g = 5'b10010;
            4'h3: g = 5'b10011;
            4'h4: g = 5'b01110;
            4'h5: g = 5'b01111;
            4'h6: g = 5'b10110;
            4'h7: g = 5'b10111;
            4'h8: g = 5'b01001;
            4'h9: g = 5'b11001;
            4'hA: g = 5'b11010;
            4'hB: g = 5'b11011;
            4'hC: g = 5'b01101;
            4'hD: g = 5'b11101;
            4'hE: g = 5'b11110;
            default: g = 5'b10101;
        endcase
        return g;
    endfunction

    function automatic nib_dec_t grp_to_nib(input grp_t g);
        nib_dec_t d;
        d.ok = 1'b1;
        case (g)
            5'b01010: d.nib = 4'h0;
            5'b01011: d.nib = 4'h1;
            5'b10010: d.nib = 4'h2;
            5'b10011: d.nib = 4'h3;
            5'b01110: d.nib = 4'h4;
            5'b01111: d.nib = 4'h5;
            5'b10110: d.nib = 4'h6;
            5'b10111: d.nib = 4'h7;
            5'b01001: d.nib = 4'h8;
            5'b11001: d.nib = 4'h9;
            5'b11010: d.nib = 4'hA;
            5'b11011: d.nib = 4'hB;
            5'b01101: d.nib = 4'hC;
            5'b11101: d.nib = 4'hD;
            5'b11110: d.nib = 4'hE;
            5'b10101: d.nib = 4'hF;
            default: begin
                d.ok  = 1'b0;
                d.nib = '0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gcr_read_shifter.sv
module gcr_read_shifter #(
    parameter int W = gcr_pkg::SYM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic         rd_mode,
    input  logic         bit_in,
    output logic [W-1:0] sr_nxt,
    output logic         sync_now,
    output logic         sync_q
);
    logic [W-1:0] sr;

    always_comb begin
        sr_nxt   = {sr[W-2:0], bit_in & rd_mode};
        sync_now = rd_mode & (&sr_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            sync_q <= 1'b0;
        end else if (stb) begin
            sr     <= sr_nxt;
            sync_q <= sync_now;
        end
    end
endmodule

// File: rtl/gcr_bit_counter.sv
module gcr_bit_counter #(
    parameter int FRAME = gcr_pkg::SYM_W
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic sync_now,
    input  logic sync_prev,
    output logic at_last,
    output logic last_nxt
);
    localparam int CW = $clog2(FRAME);
    localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        if (sync_now || sync_prev)
            cnt_nxt = '0;
        else if (cnt == LAST)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + 1'b1;
        at_last  = (cnt == LAST);
        last_nxt = (cnt_nxt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (stb)
            cnt <= cnt_nxt;
    end
endmodule

// File: rtl/gcr_code_lookup.sv
module gcr_code_lookup
    import gcr_pkg::*;
(
    input  logic     rd_mode,
    input  logic     mode_sel,
    input  sym_t     rd_sym,
    input  byte_t    wr_data,
    output lut_out_t q
);
    localparam int HI_MSB = SYM_W - 2;
    localparam int HI_LSB = NIB_W + 1;
    localparam int MODE_B = NIB_W;

    lut_addr_t addr;
    nib_dec_t  hi_dec, lo_dec;
    nib_t      wr_hi, wr_lo;

    always_comb begin
        addr.rd      = rd_mode;
        addr.payload = rd_mode ? rd_sym
                               : {1'b0, wr_data[BYTE_W-1:NIB_W], mode_sel, wr_data[NIB_W-1:0]};

        hi_dec = grp_to_nib(addr.payload[SYM_W-1 -: GRP_W]);
        lo_dec = grp_to_nib(addr.payload[GRP_W-1:0]);
        wr_hi  = addr.payload[HI_MSB:HI_LSB];
        wr_lo  = addr.payload[NIB_W-1:0];

        if (addr.rd) begin
            q.valid = hi_dec.ok & lo_dec.ok;
            q.code  = '0;
            q.data  = {hi_dec.nib, lo_dec.nib};
        end else begin
            q.valid = 1'b1;
            q.data  = {wr_hi, wr_lo};
            q.code  = addr.payload[MODE_B] ? '1 : {nib_to_grp(wr_hi), nib_to_grp(wr_lo)};
        end
    end
endmodule

// File: rtl/gcr_write_shifter.sv
module gcr_write_shifter #(
    parameter int W = gcr_pkg::SYM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         msb
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (stb) begin
            if (load)
                sr <= load_val;
            else
                sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign msb = sr[W-1];
endmodule

// File: rtl/gcr_framer.sv
module gcr_framer
    import gcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_stb,
    input  logic        bit_in,
    input  logic        rd_mode,
    input  logic        mode_sel,
    input  logic [7:0]  wr_byte,
    output logic        sync_n,
    output logic        ready_n,
    output logic        error_n,
    output logic [7:0]  rd_byte,
    output logic        wr_bit
);
    sym_t     sr_nxt;
    logic     sync_now, sync_q;
    logic     at_last, last_nxt;
    lut_out_t lut;
    logic     bad_q;
    byte_t    byte_q;
    logic     wr_msb;

    gcr_read_shifter #(.W(SYM_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .stb      (bit_stb),
        .rd_mode  (rd_mode),
        .bit_in   (bit_in),
        .sr_nxt   (sr_nxt),
        .sync_now (sync_now),
        .sync_q   (sync_q)
    );

    gcr_bit_counter #(.FRAME(SYM_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .stb       (bit_stb),
        .sync_now  (sync_now),
        .sync_prev (sync_q),
        .at_last   (at_last),
        .last_nxt  (last_nxt)
    );

    gcr_code_lookup u_lut (
        .rd_mode  (rd_mode),
        .mode_sel (mode_sel),
        .rd_sym   (sr_nxt),
        .wr_data  (wr_byte),
        .q        (lut)
    );

    gcr_write_shifter #(.W(SYM_W)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .stb      (bit_stb),
        .load     (last_nxt),
        .load_val (lut.code),
        .msb      (wr_msb)
    );

    // Boundary capture of decoded byte and legality flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            bad_q  <= 1'b0;
        end else if (bit_stb && last_nxt) begin
            bad_q <= rd_mode & ~lut.valid;
            if (rd_mode)
                byte_q <= lut.data;
        end
    end

    always_comb begin
        sync_n  = ~sync_q;
        ready_n = ~at_last;
        error_n = ~(at_last & bad_q);
        rd_byte = byte_q;
        wr_bit  = ~rd_mode & wr_msb;
    end
endmodule

// File: rtl/gcr_framer_chk.sv
module gcr_framer_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_stb,
    input logic       bit_in,
    input logic       rd_mode,
    input logic       sync_n,
    input logic       ready_n,
    input logic       error_n,
    input logic [7:0] rd_byte,
    input logic       wr_bit
);
    // R3: with sync shown, another one in read mode keeps it
    assert_sync_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!sync_n && bit_stb && rd_mode && bit_in) |=> !sync_n);

    // R4: the counter sits at zero while sync is shown
    assert_no_ready_in_sync_R4: assert property (@(posedge clk) disable iff (rst)
        !sync_n |-> ready_n);

    // R5: ready lasts one strobe interval
    assert_ready_one_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (!ready_n && bit_stb) |=> ready_n);

    // R7: error only during ready
    assert_error_in_ready_R7: assert property (@(posedge clk) disable iff (rst)
        !error_n |-> !ready_n);

    // R11: no serial output in read mode
    assert_quiet_write_R11: assert property (@(posedge clk) disable iff (rst)
        rd_mode |-> !wr_bit);

    // R12: nothing moves without a strobe
    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> ($stable(sync_n) && $stable(ready_n) && $stable(error_n) && $stable(rd_byte)));
endmodule

bind gcr_framer gcr_framer_chk u_chk (.*);

// File: tb/gcr_framer_test.sv
module gcr_framer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic       bit_in = 1'b0;
    logic       rd_mode = 1'b1;
    logic       mode_sel = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       sync_n, ready_n, error_n, wr_bit;
    logic [7:0] rd_byte;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // model state
    int msr = 0, mcnt = 0, mwsr = 0, mbyte = 0;
    bit msync = 0, merr = 0;

    int tbl [16] = '{'h0A, 'h0B, 'h12, 'h13, 'h0E, 'h0F, 'h16, 'h17,
                     'h09, 'h19, 'h1A, 'h1B, 'h0D, 'h1D, 'h1E, 'h15};

    gcr_framer uut (.*);

    always #5 clk = ~clk;

    function automatic int enc(int b);
        return (tbl[(b >> 4) & 15] << 5) | tbl[b & 15];
    endfunction

    function automatic int find(int g);
        for (int i = 0; i < 16; i++) if (tbl[i] == g) return i;
        return -1;
    endfunction

    function automatic bit legal(int s);
        return (find((s >> 5) & 31) >= 0) && (find(s & 31) >= 0);
    endfunction

    function automatic int dec(int s);
        int h = find((s >> 5) & 31);
        int l = find(s & 31);
        if (h < 0) h = 0;
        if (l < 0) l = 0;
        return (h << 4) | l;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // full comparison against the model
    task automatic compare_all();
        chk("R3", "sync_n", sync_n, !msync);
        chk("R4", "ready_n", ready_n, !(mcnt == 9));
        chk("R7", "error_n", error_n, !(mcnt == 9 && merr));
        chk("R6", "rd_byte", rd_byte, mbyte);
        chk("R9", "wr_bit", wr_bit, rd_mode ? 0 : ((mwsr >> 9) & 1));
    endtask

    // one clock: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic cyc(input bit s, input bit b);
        bit ib, sy;
        bit_stb = s;
        bit_in  = b;
        @(posedge clk);
        if (s) begin
            ib  = rd_mode ? b : 1'b0;
            msr = ((msr << 1) | ib) & 1023;
            sy  = rd_mode && (msr == 1023);
            if (sy || msync) mcnt = 0;
            else mcnt = (mcnt == 9) ? 0 : mcnt + 1;
            msync = sy;
            if (mcnt == 9) begin
                merr = rd_mode && !legal(msr);
                if (rd_mode) mbyte = dec(msr);
                mwsr = rd_mode ? 0 : (mode_sel ? 1023 : enc(wr_byte));
            end else begin
                mwsr = (mwsr << 1) & 1023;
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) cyc(1, 1);
    endtask

    task automatic send_sym(input int s);
        for (int i = 9; i >= 0; i--) cyc(1, (s >> i) & 1);
    endtask

    // collect one written symbol starting at the next boundary
    task automatic grab_write(output int got);
        do cyc(1, 0); while (ready_n !== 1'b0);
        got = wr_bit;
        for (int i = 0; i < 9; i++) begin
            cyc(1, 0);
            got = (got << 1) | wr_bit;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        int got;
        int bytes [4] = '{'h08, 'hA5, 'h3C, 'hFF};
        logic [7:0] held;

        // reset
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1", "sync_n in reset", sync_n, 1);
        chk("R1", "ready_n in reset", ready_n, 1);
        chk("R1", "error_n in reset", error_n, 1);
        chk("R1", "rd_byte in reset", rd_byte, 0);
        chk("R1", "wr_bit in reset", wr_bit, 0);
        rst = 0;
        cyc(0, 0);
        chk("R1", "ready_n after release", ready_n, 1);

        // sync detection and framed read
        send_ones(9);
        chk("R3", "no sync after nine ones", sync_n, 1);
        send_ones(3);
        chk("R3", "sync after ten ones", sync_n, 0);
        foreach (bytes[k]) begin
            send_sym(enc(bytes[k]));
            chk("R4", "ready at symbol end", ready_n, 0);
            chk("R6", "decoded byte", rd_byte, bytes[k]);
            chk("R2", "read order msb first", rd_byte, bytes[k]);
            chk("R7", "legal code no error", error_n, 1);
        end
        cyc(1, 0);
        chk("R5", "ready clears next strobe", ready_n, 1);

        // illegal symbol
        send_ones(11);
        send_sym(0);
        chk("R7", "illegal code flags error", error_n, 0);
        chk("R6", "illegal groups decode to zero", rd_byte, 0);

        // idle with toggling inputs
        held = rd_byte;
        for (int i = 0; i < 12; i++) begin
            mode_sel = i[0];
            wr_byte  = 8'(i * 37);
            cyc(0, i[1]);
        end
        chk("R12", "rd_byte held without strobe", rd_byte, held);
        chk("R11", "no write bit in read mode", wr_bit, 0);
        mode_sel = 0;

        // write mode
        rd_mode = 0;
        cyc(0, 0);
        wr_byte = 8'h5A;
        grab_write(got);
        chk("R9", "encoded symbol 5A", got, enc('h5A));
        chk("R8", "table code for 5A", got, ('h0F << 5) | 'h1A);
        wr_byte = 8'h00;
        grab_write(got);
        chk("R9", "encoded symbol 00", got, enc(0));
        chk("R7", "no error in write mode", error_n, 1);
        mode_sel = 1;
        grab_write(got);
        chk("R10", "sync mark written", got, 1023);
        mode_sel = 0;
        for (int b = 0; b < 16; b++) begin
            wr_byte = 8'((b << 4) | (15 - b));
            grab_write(got);
            chk("R8", "nibble table", got, (tbl[b] << 5) | tbl[15 - b]);
        end

        // random read traffic with gaps
        rd_mode = 1;
        cyc(1, 0);
        for (int blk = 0; blk < 40; blk++) begin
            if (blk % 3 == 0) begin
                send_ones(11);
                cyc(1, 0);
            end
            for (int i = 0; i < 60; i++) begin
                if ($urandom_range(0, 3) == 0) cyc(0, 1'($urandom));
                else cyc(1, 1'($urandom));
            end
        end
        chk("R11", "wr_bit quiet after read traffic", wr_bit, 0);

        finish_run();
    end
endmodule